// File: doc/BRIEF.md
# Multi-Profile Configuration Section Decryptor

This block sits on the path that carries an aggregated configuration stream into a programmable device. The stream is a run of sections. Each section opens with a two-word header that names the key profile to use, the number of payload words that follow, the frame position the section starts at and the height of the region in rows. The block looks up the key for that profile in a table supplied by the key-storage logic next to it. It restarts a key-seeded keystream generator, strips the keystream from every payload word and hands each plaintext word, with its frame address, to a configuration-write port.

Each section picks its own key, so payloads protected under different keys can be mixed in one stream in any order and each lands in its own region. A section that names a missing or unusable profile, or a region height that does not fit the row tiling, is consumed and thrown away whole, and an error pulse reports why. Both the input side and the output side use valid/ready handshakes. Output backpressure holds the input, and no word is lost or repeated.

Top module: `cfg_section_decrypt`

## Requirements
- R1: Header word 0 is {marker [31:24] = 8'hA5, profile index [23:16], payload length in words [15:0]}. A header word 0 with any other marker is discarded with error code 1, and the next input word is taken as a new header word 0.
- R2: Payload word k of a section leaves as in_data XOR ks_k. ks_0 is the profile key, or 32'h1 when the key is zero. ks_(k+1) is ks_k shifted right by one, XORed with 32'h80200003 when bit 0 of ks_k was 1. The sequence restarts at every section.
- R3: The key for profile p is prof_keys[p*32 +: 32]. When p >= NPROF, or prof_key_ok[p] is 0, the section's payload gives no output and error code 2 is reported.
- R4: Header word 1 is {start row [31:24], start column [23:16], row span [15:0]}. out_addr of payload word k is {row, column} + k, modulo 2^16.
- R5: A row span of zero, or one that is not a multiple of 16, makes the section's payload give no output and reports error code 3. When both checks fail, code 2 wins over code 3.
- R6: A rejected section still consumes exactly its declared length in payload words, and the word after them is parsed as a new header.
- R7: The result of a section does not depend on which sections came before it or in what order.
- R8: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_addr hold. Every accepted payload word of a good section appears exactly once, in order.
- R9: A section with length 0 has no payload, and the next word is a header word 0.
- R10: After reset, out_valid and err_pulse are 0 and in_ready is 1.
- R11: err_pulse is high for exactly one cycle, in the cycle after the handshake of the offending header word, with err_code giving the reason. err_code is 0 whenever err_pulse is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block accepts the input word |
| in_data | input | 32 | Input stream word (header or ciphertext) |
| prof_keys | input | NPROF*32 | Key table, profile p in bits [p*32 +: 32] |
| prof_key_ok | input | NPROF | Per-profile key valid flags |
| out_valid | output | 1 | Plaintext word valid |
| out_ready | input | 1 | Configuration port accepts the word |
| out_data | output | 32 | Plaintext word |
| out_addr | output | 16 | Frame address of the word |
| err_pulse | output | 1 | One-cycle header error indication |
| err_code | output | 2 | 1 bad marker, 2 bad profile, 3 bad row span |

## Verification
The bench builds the block with NPROF set to 3, so a profile index of 3 in a header reaches the out-of-range rejection, while clearing one bit of prof_key_ok reaches the in-range invalid-key path. TILE_ROWS stays at 16, so spans of 16, 24 and 0 cover the accepted case and both rejection cases. One profile holds an all-zero key, which brings the keystream's seed replacement into reach. A start address near 16'hFFFF brings the address wraparound into reach.

// File: rtl/sdec_pkg.sv
package sdec_pkg;

  localparam int WORD_W = 32;
  localparam int ADDR_W = 16;
  localparam int LEN_W  = 16;
  localparam logic [7:0] HDR_MARKER = 8'hA5;

  typedef enum logic [1:0] {
    ST_HDR0 = 2'd0,
    ST_HDR1 = 2'd1,
    ST_PAY  = 2'd2,
    ST_DROP = 2'd3
  } sdec_state_e;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_MARKER  = 2'd1,
    ERR_PROFILE = 2'd2,
    ERR_SPAN    = 2'd3
  } sdec_err_e;

  function automatic logic [7:0] hdr_marker(input logic [WORD_W-1:0] w);
    return w[31:24];
  endfunction

  function automatic logic [7:0] hdr_profile(input logic [WORD_W-1:0] w);
    return w[23:16];
  endfunction

  function automatic logic [LEN_W-1:0] hdr_length(input logic [WORD_W-1:0] w);
    return w[15:0];
  endfunction

  function automatic logic [ADDR_W-1:0] hdr_base(input logic [WORD_W-1:0] w);
    return w[31:16];
  endfunction

  function automatic logic [15:0] hdr_span(input logic [WORD_W-1:0] w);
    return w[15:0];
  endfunction

endpackage

// File: rtl/sdec_keystream.sv
module sdec_keystream #(
  parameter int W = 32,
  parameter logic [W-1:0] POLY = 32'h80200003
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         adv,
  output logic [W-1:0] ks
);

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  function automatic logic [W-1:0] seed_of(input logic [W-1:0] k);
    return (k == '0) ? ONE : k;
  endfunction

  function automatic logic [W-1:0] step_of(input logic [W-1:0] s);
    return (s >> 1) ^ (s[0] ? POLY : '0);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)    ks <= ONE;
    else if (load) ks <= seed_of(seed);
    else if (adv)  ks <= step_of(ks);
  end

endmodule

// File: rtl/sdec_hdr_check.sv
module sdec_hdr_check
  import sdec_pkg::*;
#(
  parameter int NPROF     = 4,
  parameter int TILE_ROWS = 16
) (
  input  logic [WORD_W-1:0]       cur_word,
  input  logic [7:0]              prof_q,
  input  logic [NPROF*WORD_W-1:0] prof_keys,
  input  logic [NPROF-1:0]        prof_key_ok,
  output logic                    marker_ok,
  output logic                    prof_ok,
  output logic                    span_ok,
  output logic [WORD_W-1:0]       sel_key
);

  function automatic logic tile_aligned(input logic [15:0] s);
    return (s != 16'd0) && ((32'(s) % TILE_ROWS) == 0);
  endfunction

  assign marker_ok = (hdr_marker(cur_word) == HDR_MARKER);
  assign span_ok   = tile_aligned(hdr_span(cur_word));

  always_comb begin
    sel_key = '0;
    prof_ok = 1'b0;
    for (int i = 0; i < NPROF; i++) begin
      if (prof_q == i[7:0]) begin
        sel_key = prof_keys[i*WORD_W +: WORD_W];
        prof_ok = prof_key_ok[i];
      end
    end
  end

endmodule

// File: rtl/sdec_addr_gen.sv
module sdec_addr_gen #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic [LEN_W-1:0]  len,
  input  logic              step,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              is_last
);

  logic [LEN_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr <= '0;
      remain   <= '0;
    end else if (load) begin
      cur_addr <= base;
      remain   <= len;
    end else if (step) begin
      cur_addr <= cur_addr + 1'b1;
      remain   <= remain - 1'b1;
    end
  end

  assign is_last = (remain == {{(LEN_W-1){1'b0}}, 1'b1});

endmodule

// File: rtl/cfg_section_decrypt.sv
module cfg_section_decrypt
  import sdec_pkg::*;
#(
  parameter int NPROF         = 4,
  parameter int TILE_ROWS     = 16,
  parameter logic [31:0] POLY = 32'h80200003
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [WORD_W-1:0]       in_data,
  input  logic [NPROF*WORD_W-1:0] prof_keys,
  input  logic [NPROF-1:0]        prof_key_ok,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [WORD_W-1:0]       out_data,
  output logic [ADDR_W-1:0]       out_addr,
  output logic                    err_pulse,
  output logic [1:0]              err_code
);

  sdec_state_e state, state_nxt;
  logic [7:0]       prof_q;
  logic [LEN_W-1:0] len_q;
  logic             marker_ok, prof_ok, span_ok;
  logic [WORD_W-1:0] sel_key, ks;
  logic [ADDR_W-1:0] cur_addr;
  logic             is_last;
  sdec_err_e        err_q;

  // named internal events
  logic in_fire, hdr0_take, hdr1_take, pay_take, drop_take, sec_good, sec_bad;

  assign in_ready  = (state == ST_PAY) ? (!out_valid || out_ready) : 1'b1;
  assign in_fire   = in_valid && in_ready;
  assign hdr0_take = in_fire && (state == ST_HDR0);
  assign hdr1_take = in_fire && (state == ST_HDR1);
  assign pay_take  = in_fire && (state == ST_PAY);
  assign drop_take = in_fire && (state == ST_DROP);
  assign sec_good  = hdr1_take && prof_ok && span_ok;
  assign sec_bad   = hdr1_take && !(prof_ok && span_ok);

  sdec_hdr_check #(.NPROF(NPROF), .TILE_ROWS(TILE_ROWS)) u_hdr_check (
    .cur_word   (in_data),
    .prof_q     (prof_q),
    .prof_keys  (prof_keys),
    .prof_key_ok(prof_key_ok),
    .marker_ok  (marker_ok),
    .prof_ok    (prof_ok),
    .span_ok    (span_ok),
    .sel_key    (sel_key)
  );

  sdec_keystream #(.W(WORD_W), .POLY(POLY)) u_keystream (
    .clk  (clk),
    .rst_n(rst_n),
    .load (sec_good),
    .seed (sel_key),
    .adv  (pay_take),
    .ks   (ks)
  );

  sdec_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_addr_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (hdr1_take),
    .base    (hdr_base(in_data)),
    .len     (len_q),
    .step    (pay_take || drop_take),
    .cur_addr(cur_addr),
    .is_last (is_last)
  );

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_HDR0: if (hdr0_take && marker_ok) state_nxt = ST_HDR1;
      ST_HDR1: if (hdr1_take) begin
        if (len_q == '0)   state_nxt = ST_HDR0;
        else if (sec_good) state_nxt = ST_PAY;
        else               state_nxt = ST_DROP;
      end
      ST_PAY:  if (pay_take && is_last)  state_nxt = ST_HDR0;
      ST_DROP: if (drop_take && is_last) state_nxt = ST_HDR0;
      default: state_nxt = ST_HDR0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_HDR0;
      prof_q <= '0;
      len_q  <= '0;
    end else begin
      state <= state_nxt;
      if (hdr0_take && marker_ok) begin
        prof_q <= hdr_profile(in_data);
        len_q  <= hdr_length(in_data);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_addr  <= '0;
    end else if (pay_take) begin
      out_valid <= 1'b1;
      out_data  <= in_data ^ ks;
      out_addr  <= cur_addr;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_pulse <= 1'b0;
      err_q     <= ERR_NONE;
    end else if (hdr0_take && !marker_ok) begin
      err_pulse <= 1'b1;
      err_q     <= ERR_MARKER;
    end else if (sec_bad) begin
      err_pulse <= 1'b1;
      err_q     <= prof_ok ? ERR_SPAN : ERR_PROFILE;
    end else begin
      err_pulse <= 1'b0;
      err_q     <= ERR_NONE;
    end
  end

  assign err_code = err_q;

endmodule

// File: rtl/sdec_checker.sv
module sdec_checker
  import sdec_pkg::*;
#(
  parameter int NPROF     = 4,
  parameter int TILE_ROWS = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic [ADDR_W-1:0] out_addr,
  input logic              err_pulse,
  input logic [1:0]        err_code,
  input sdec_state_e       state,
  input logic              pay_take,
  input logic              sec_good,
  input logic [7:0]        sec_prof,
  input logic [15:0]       sec_span,
  input logic [NPROF-1:0]  prof_key_ok
);

  assert_hold_under_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_addr));

  assert_pay_word_emitted_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pay_take |=> out_valid);

  assert_drop_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DROP) && !out_valid |=> !out_valid);

  assert_good_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sec_good |-> (int'(sec_prof) < NPROF) && (((prof_key_ok >> sec_prof) & 1'b1) != '0));

  assert_span_tiled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sec_good |-> (sec_span != 16'd0) && ((32'(sec_span) % TILE_ROWS) == 0));

  assert_err_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse ? (err_code != 2'd0) : (err_code == 2'd0));

  assert_err_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse && (err_code == 2'd1) |=> !err_pulse);

endmodule

bind cfg_section_decrypt sdec_checker #(.NPROF(NPROF), .TILE_ROWS(TILE_ROWS)) u_sdec_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .out_addr   (out_addr),
  .err_pulse  (err_pulse),
  .err_code   (err_code),
  .state      (state),
  .pay_take   (pay_take),
  .sec_good   (sec_good),
  .sec_prof   (prof_q),
  .sec_span   (in_data[15:0]),
  .prof_key_ok(prof_key_ok)
);

// File: tb/test_cfg_section_decrypt.sv
module test_cfg_section_decrypt;

  localparam int NP = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [31:0]   in_data = '0;
  logic [NP*32-1:0] prof_keys;
  logic [NP-1:0] prof_key_ok = 3'b111;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [31:0]   out_data;
  logic [15:0]   out_addr;
  logic          err_pulse;
  logic [1:0]    err_code;

  localparam logic [31:0] K0 = 32'h1234_5678;
  localparam logic [31:0] K1 = 32'hDEAD_BEEF;
  localparam logic [31:0] K2 = 32'h0000_0000;
  assign prof_keys = {K2, K1, K0};

  cfg_section_decrypt #(.NPROF(NP)) i_cfg_section_decrypt (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .prof_keys(prof_keys), .prof_key_ok(prof_key_ok), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_addr(out_addr),
    .err_pulse(err_pulse), .err_code(err_code)
  );

  int n_chk = 0, n_fail = 0;
  int stall = 0;
  int cyc = 0;
  logic [31:0] got_d[$], exp_d[$];
  logic [15:0] got_a[$], exp_a[$];
  logic [1:0]  got_e[$];

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #2;
    out_ready = (stall == 0) ? 1'b1 : ((cyc % 3) != 0);
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && out_ready) begin
        got_d.push_back(out_data);
        got_a.push_back(out_addr);
      end
      if (err_pulse) got_e.push_back(err_code);
    end
  end

  // keystream written independently from the requirement text
  function automatic logic [31:0] tb_seed(input logic [31:0] k);
    if (k == 32'd0) return 32'd1;
    return k;
  endfunction

  function automatic logic [31:0] tb_step(input logic [31:0] s);
    logic [31:0] r;
    r = {1'b0, s[31:1]};
    if (s[0]) r = r ^ 32'h8020_0003;
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] w);
    in_valid = 1'b1;
    in_data  = w;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk);
    #2;
    in_valid = 1'b0;
  endtask

  task automatic section(input logic [7:0] prof, input logic [15:0] len, input logic [7:0] row,
                         input logic [7:0] col, input logic [15:0] span, input logic [31:0] key,
                         input bit good, input logic [7:0] tagb);
    logic [31:0] s;
    logic [31:0] plain;
    put({8'hA5, prof, len});
    put({row, col, span});
    s = tb_seed(key);
    for (int k = 0; k < int'(len); k++) begin
      plain = {8'hC3, tagb, 16'(k * 7 + 1)};
      put(plain ^ s);
      if (good) begin
        exp_d.push_back(plain);
        exp_a.push_back(16'({row, col}) + 16'(k));
      end
      s = tb_step(s);
    end
  endtask

  task automatic drain();
    repeat (60) @(posedge clk);
    #2;
  endtask

  task automatic compare(input string tag);
    check(got_d.size() == exp_d.size(), {tag, " word count"}, 64'(got_d.size()), 64'(exp_d.size()));
    if (got_d.size() == exp_d.size()) begin
      for (int i = 0; i < exp_d.size(); i++) begin
        check(got_d[i] == exp_d[i], {tag, " data"}, 64'(got_d[i]), 64'(exp_d[i]));
        check(got_a[i] == exp_a[i], {tag, " addr R4"}, 64'(got_a[i]), 64'(exp_a[i]));
      end
    end
    got_d.delete(); got_a.delete(); exp_d.delete(); exp_a.delete();
  endtask

  task automatic expect_err(input string tag, input logic [1:0] code);
    check(got_e.size() == 1, {tag, " one err pulse R11"}, 64'(got_e.size()), 64'd1);
    if (got_e.size() == 1) check(got_e[0] == code, {tag, " err code"}, 64'(got_e[0]), 64'(code));
    got_e.delete();
  endtask

  task automatic expect_no_err(input string tag);
    check(got_e.size() == 0, {tag, " no err R11"}, 64'(got_e.size()), 64'd0);
    got_e.delete();
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(out_valid == 1'b0, "R10 out_valid after reset", 64'(out_valid), 64'd0);
    check(err_pulse == 1'b0, "R10 err_pulse after reset", 64'(err_pulse), 64'd0);
    check(in_ready == 1'b1, "R10 in_ready after reset", 64'(in_ready), 64'd1);
    @(posedge clk); #2;
  endtask

  task automatic t_basic();
    section(8'd0, 16'd5, 8'h05, 8'h10, 16'd16, K0, 1, 8'h01);
    drain();
    compare("R2 basic decrypt");
    expect_no_err("R2 basic");
  endtask

  task automatic t_zero_key_wrap();
    section(8'd2, 16'd4, 8'hFF, 8'hFE, 16'd32, K2, 1, 8'h02);
    drain();
    compare("R2 zero key seed, R4 wrap");
  endtask

  task automatic t_order();
    section(8'd1, 16'd3, 8'h20, 8'h00, 16'd16, K1, 1, 8'h0A);
    section(8'd0, 16'd3, 8'h40, 8'h08, 16'd48, K0, 1, 8'h0B);
    drain();
    compare("R7 order A then B");
    section(8'd0, 16'd3, 8'h40, 8'h08, 16'd48, K0, 1, 8'h0B);
    section(8'd1, 16'd3, 8'h20, 8'h00, 16'd16, K1, 1, 8'h0A);
    drain();
    compare("R7 order B then A");
  endtask

  task automatic t_backpressure();
    stall = 1;
    section(8'd1, 16'd9, 8'h33, 8'h44, 16'd16, K1, 1, 8'h0C);
    section(8'd0, 16'd4, 8'h01, 8'h02, 16'd16, K0, 1, 8'h0D);
    drain();
    stall = 0;
    drain();
    compare("R8 backpressure");
  endtask

  task automatic t_bad_profile();
    section(8'd3, 16'd3, 8'h10, 8'h10, 16'd16, K0, 0, 8'h0E);
    drain();
    expect_err("R3 profile out of range", 2'd2);
    prof_key_ok = 3'b011;
    section(8'd2, 16'd2, 8'h10, 8'h10, 16'd16, K2, 0, 8'h0F);
    drain();
    expect_err("R3 profile key invalid", 2'd2);
    section(8'd0, 16'd2, 8'h12, 8'h00, 16'd16, K0, 1, 8'h10);
    drain();
    compare("R6 drop then resume");
    prof_key_ok = 3'b111;
  endtask

  task automatic t_bad_span();
    section(8'd0, 16'd2, 8'h50, 8'h00, 16'd24, K0, 0, 8'h11);
    drain();
    expect_err("R5 span 24", 2'd3);
    section(8'd1, 16'd1, 8'h50, 8'h00, 16'd0, K1, 0, 8'h12);
    drain();
    expect_err("R5 span 0", 2'd3);
    section(8'd3, 16'd1, 8'h50, 8'h00, 16'd5, K1, 0, 8'h13);
    drain();
    expect_err("R5 priority code 2 over 3", 2'd2);
    compare("R5 no output from rejected sections");
  endtask

  task automatic t_bad_marker();
    put(32'h1200_0003);
    section(8'd1, 16'd2, 8'h60, 8'h60, 16'd16, K1, 1, 8'h14);
    drain();
    expect_err("R1 bad marker", 2'd1);
    compare("R1 resync after bad marker");
  endtask

  task automatic t_zero_len();
    section(8'd0, 16'd0, 8'h70, 8'h00, 16'd16, K0, 1, 8'h15);
    section(8'd1, 16'd2, 8'h71, 8'h00, 16'd16, K1, 1, 8'h16);
    drain();
    compare("R9 zero length section");
    expect_no_err("R9 zero length");
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #2;
    rst_n = 1'b1;
    fork
      begin
        t_reset();
        t_basic();
        t_zero_key_wrap();
        t_order();
        t_backpressure();
        t_bad_profile();
        t_bad_span();
        t_bad_marker();
        t_zero_len();
      end
      begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 64'd1, 64'd0);
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule